// File: doc/BRIEF.md
# PFC Startup and Fault Supervisor

This block sequences the power-up of a critical-conduction boost PFC controller and takes it out of switching when something is wrong. Its inputs are single-bit results of analog threshold comparators: the supply rail against its turn-on and turn-off levels, the feedback node against its undervoltage level, and the amplifier sink current against an overvoltage trip level and a lower release level. It also takes a "control node at its lower clamp" bit and an external shutdown request. From these it produces three enables: one for the error amplifier, one for the gate drive and one for the restart watchdog. It also produces a one-cycle preset pulse that pulls the control node to its lower clamp when the amplifier first turns on, and an encoded state output.

The supply has hysteresis. The block leaves lockout when the turn-on comparator fires, and it falls back to lockout whenever the turn-off comparator fires, whatever state it is in. After lockout the amplifier is held off for a fixed wait while the feedback level is checked. A feedback level that is still low at the end of the wait is treated as an open loop, and the block parks in an undervoltage fault until the feedback level recovers. During normal running, two overvoltage detectors can stop the drive. The first is a sink-current detector that latches and has release hysteresis. The second is a static detector that acts directly on the lower clamp of the control node.

Top module: `pfc_supervisor`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it is released, the state is lockout and ea_en_o, drv_en_o, wdog_en_o and ctrl_preset_o are all 0.
- R2: In lockout, the block stays in lockout while vcc_on_i is 0. When vcc_on_i is 1 at a clock edge, the block enters the wait state at that edge.
- R3: The wait state lasts exactly WAIT_CYCLES clock cycles. During the wait, ea_en_o, drv_en_o and wdog_en_o are 0.
- R4: At the last wait cycle the block samples fb_uvp_i. If fb_uvp_i is 1, the next state is undervoltage fault. Otherwise the next state is run.
- R5: In undervoltage fault, all enables are 0. The first edge that sees fb_uvp_i at 0 moves the block to run.
- R6: In run, ea_en_o is 1. ctrl_preset_o is 1 only in the first cycle of each stay in run.
- R7: In run, a clock edge that sees isink_trip_i at 1 sets the dynamic overvoltage latch. From the next cycle, drv_en_o and wdog_en_o are 0. They stay 0 until an edge sees isink_rel_i at 1 with isink_trip_i at 0, and they return from the cycle after that edge. The latch is clear whenever the block enters run.
- R8: In run, ctrl_clamp_i at 1 forces drv_en_o and wdog_en_o to 0 in the same cycle, with no added delay. Both outputs return as soon as ctrl_clamp_i falls, unless the dynamic latch is set.
- R9: When shutdown_i is 1 at an edge in any state except lockout, the block enters shutdown and all enables are 0. The first edge with shutdown_i at 0 moves it to the wait state.
- R10: When vcc_off_i is 1 at an edge, the block returns to lockout at that edge from any state. This takes priority over shutdown and over every other input.
- R11: The state_o encoding is lockout=0, wait=1, undervoltage fault=2, run=3, shutdown=4.
- R12: In run, a clock edge that sees fb_uvp_i at 1 moves the block to undervoltage fault, unless vcc_off_i or shutdown_i takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| vcc_on_i | input | 1 | Supply is above the turn-on level |
| vcc_off_i | input | 1 | Supply is below the turn-off level |
| fb_uvp_i | input | 1 | Feedback is below the undervoltage level |
| isink_trip_i | input | 1 | Amplifier sink current is above the overvoltage trip level |
| isink_rel_i | input | 1 | Amplifier sink current is below the release level |
| ctrl_clamp_i | input | 1 | Control node is at its lower clamp |
| shutdown_i | input | 1 | External shutdown request |
| ea_en_o | output | 1 | Error amplifier enable |
| drv_en_o | output | 1 | Gate drive enable |
| wdog_en_o | output | 1 | Restart watchdog enable |
| ctrl_preset_o | output | 1 | One-cycle preset of the control node to its lower clamp |
| state_o | output | 3 | Encoded supervisor state |

## Verification
The bench builds the block with WAIT_CYCLES set to 8 instead of the default real-time figure. This makes the feedback check at the end of the wait, the run, fault and shutdown transitions, and repeated restarts through lockout each take only a few dozen cycles. With that setting, one short run can cover every state-to-state transition, including the priority cases: the turn-off comparator firing together with shutdown, and an overvoltage trip held across its release hysteresis.

// File: rtl/pfc_sup_pkg.sv
package pfc_sup_pkg;
  typedef enum logic [2:0] {
    ST_LOCKOUT  = 3'd0,
    ST_WAIT     = 3'd1,
    ST_UVP      = 3'd2,
    ST_RUN      = 3'd3,
    ST_SHUTDOWN = 3'd4
  } sup_state_e;
endpackage

// File: rtl/pfc_sup_timer.sv
module pfc_sup_timer #(
  parameter int unsigned WAIT_CYCLES = 22500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  localparam int unsigned CW = $clog2(WAIT_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(WAIT_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = run_i && (cnt_q == LAST);

  a_r3_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(WAIT_CYCLES));
  a_r3_cnt_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_q == '0);
endmodule

// File: rtl/pfc_sup_ovp.sv
module pfc_sup_ovp (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic trip_i,
  input  logic rel_i,
  input  logic clamp_i,
  output logic block_o
);
  logic dyn_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        dyn_q <= 1'b0;
    else if (!active_i) dyn_q <= 1'b0;
    else if (trip_i)    dyn_q <= 1'b1;
    else if (rel_i)     dyn_q <= 1'b0;
  end

  // static path is deliberately combinational
  assign block_o = dyn_q || clamp_i;

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dyn_q && active_i && !rel_i) |=> dyn_q);
  a_r7_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && trip_i) |=> dyn_q);
endmodule

// File: rtl/pfc_sup_fsm.sv
module pfc_sup_fsm
  import pfc_sup_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       vcc_on_i,
  input  logic       vcc_off_i,
  input  logic       fb_uvp_i,
  input  logic       shutdown_i,
  input  logic       wait_done_i,
  output sup_state_e state_o,
  output logic       preset_o
);
  sup_state_e state_q, state_d;
  logic preset_q;

  always_comb begin
    state_d = state_q;
    if (vcc_off_i) begin
      state_d = ST_LOCKOUT;
    end else if (shutdown_i && state_q != ST_LOCKOUT) begin
      state_d = ST_SHUTDOWN;
    end else begin
      unique case (state_q)
        ST_LOCKOUT:  if (vcc_on_i) state_d = ST_WAIT;
        ST_WAIT:     if (wait_done_i) state_d = fb_uvp_i ? ST_UVP : ST_RUN;
        ST_UVP:      if (!fb_uvp_i) state_d = ST_RUN;
        ST_RUN:      if (fb_uvp_i) state_d = ST_UVP;
        ST_SHUTDOWN: state_d = ST_WAIT;
        default:     state_d = ST_LOCKOUT;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_LOCKOUT;
      preset_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      preset_q <= (state_d == ST_RUN) && (state_q != ST_RUN);
    end
  end

  assign state_o  = state_q;
  assign preset_o = preset_q;

  a_r10_lockout_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vcc_off_i |=> state_q == ST_LOCKOUT);
  a_r9_shutdown_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vcc_off_i && shutdown_i && state_q != ST_LOCKOUT) |=> state_q == ST_SHUTDOWN);
  a_r2_stay_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LOCKOUT && !vcc_on_i) |=> state_q == ST_LOCKOUT);
endmodule

// File: rtl/pfc_supervisor.sv
module pfc_supervisor
  import pfc_sup_pkg::*;
#(
  parameter int unsigned WAIT_CYCLES = 22500
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       vcc_on_i,
  input  logic       vcc_off_i,
  input  logic       fb_uvp_i,
  input  logic       isink_trip_i,
  input  logic       isink_rel_i,
  input  logic       ctrl_clamp_i,
  input  logic       shutdown_i,
  output logic       ea_en_o,
  output logic       drv_en_o,
  output logic       wdog_en_o,
  output logic       ctrl_preset_o,
  output logic [2:0] state_o
);
  sup_state_e state;
  logic wait_done, ovp_block, running;

  pfc_sup_timer #(.WAIT_CYCLES(WAIT_CYCLES)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (state == ST_WAIT),
    .done_o (wait_done)
  );

  pfc_sup_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .vcc_on_i    (vcc_on_i),
    .vcc_off_i   (vcc_off_i),
    .fb_uvp_i    (fb_uvp_i),
    .shutdown_i  (shutdown_i),
    .wait_done_i (wait_done),
    .state_o     (state),
    .preset_o    (ctrl_preset_o)
  );

  assign running = (state == ST_RUN);

  pfc_sup_ovp u_ovp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .active_i(running),
    .trip_i  (isink_trip_i),
    .rel_i   (isink_rel_i),
    .clamp_i (ctrl_clamp_i),
    .block_o (ovp_block)
  );

  assign ea_en_o   = running;
  assign drv_en_o  = running && !ovp_block;
  assign wdog_en_o = running && !ovp_block;
  assign state_o   = state;

  a_r8_static_ovp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_clamp_i |-> !drv_en_o && !wdog_en_o);
  a_r5_uvp_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd2) |-> !ea_en_o && !drv_en_o && !wdog_en_o);
  a_r6_preset_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ea_en_o) |-> ctrl_preset_o);
  a_r6_preset_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_preset_o |=> !ctrl_preset_o);
endmodule

// File: tb/pfc_supervisor_bench.sv
module pfc_supervisor_bench;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vcc_on = 0, vcc_off = 0, fb_uvp = 0, trip = 0, rel = 0, clamp = 0, sd = 0;
  logic ea, drv, wdog, pre;
  logic [2:0] st;

  int errors = 0, checks = 0, cycles = 0;
  int m_st = 0, m_cnt = 0;
  bit m_ovp = 0, m_pre = 0;

  always #4 clk = ~clk;

  pfc_supervisor #(.WAIT_CYCLES(W)) u_pfc_supervisor (
    .clk_i(clk), .rst_ni(rst_n), .vcc_on_i(vcc_on), .vcc_off_i(vcc_off),
    .fb_uvp_i(fb_uvp), .isink_trip_i(trip), .isink_rel_i(rel),
    .ctrl_clamp_i(clamp), .shutdown_i(sd), .ea_en_o(ea), .drv_en_o(drv),
    .wdog_en_o(wdog), .ctrl_preset_o(pre), .state_o(st)
  );

  // behavioural reference
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_ovp = 0; m_pre = 0;
    end else begin
      int old_st, nxt;
      old_st = m_st;
      nxt = m_st;
      if (vcc_off) nxt = 0;
      else if (sd && m_st != 0) nxt = 4;
      else if (m_st == 0) begin if (vcc_on) nxt = 1; end
      else if (m_st == 1) begin if (m_cnt == W - 1) nxt = fb_uvp ? 2 : 3; end
      else if (m_st == 2) begin if (!fb_uvp) nxt = 3; end
      else if (m_st == 3) begin if (fb_uvp) nxt = 2; end
      else nxt = 1;
      if (old_st != 3) m_ovp = 0;
      else if (trip) m_ovp = 1;
      else if (rel) m_ovp = 0;
      m_cnt = (old_st == 1 && m_cnt < W - 1) ? m_cnt + 1 : 0;
      m_pre = (nxt == 3) && (old_st != 3);
      m_st = nxt;
    end
  end

  function automatic string tag_of(int s);
    case (s)
      0: return "R10";
      1: return "R3";
      2: return "R5";
      3: return "R6";
      default: return "R9";
    endcase
  endfunction

  task automatic chk1(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit run;
    string t;
    run = (m_st == 3);
    t = tag_of(m_st);
    chk1("R11", "state_o", st, m_st);
    chk1(t, "ea_en_o", ea, run);
    chk1(clamp ? "R8" : "R7", "drv_en_o", drv, run && !m_ovp && !clamp);
    chk1(clamp ? "R8" : "R7", "wdog_en_o", wdog, run && !m_ovp && !clamp);
    chk1("R6", "ctrl_preset_o", pre, m_pre);
  endtask

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      compare_all();
    end
  endtask

  task automatic expect_state(string req, int exp);
    chk1(req, "state_o", st, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2;
    chk1("R1", "state_o in reset", st, 0);
    chk1("R1", "drv_en_o in reset", drv, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    step(1);
    expect_state("R1", 0);
    step(4);                        // R2: no turn-on yet
    expect_state("R2", 0);

    vcc_on = 1; clamp = 1; step(1);
    expect_state("R2", 1);
    vcc_on = 0;
    step(W - 1);
    expect_state("R3", 1);          // still waiting at last wait cycle
    step(1);
    expect_state("R4", 3);
    chk1("R6", "preset first run cycle", pre, 1);
    chk1("R8", "clamp blocks drive", drv, 0);
    step(2);
    clamp = 0; #1;
    chk1("R8", "clamp release same cycle", drv, 1);
    step(2);

    trip = 1; step(1);
    chk1("R7", "trip blocks drive", drv, 0);
    trip = 0; step(4);
    chk1("R7", "held until release", drv, 0);
    rel = 1; step(1);
    chk1("R7", "released", drv, 1);
    rel = 0; step(2);

    fb_uvp = 1; step(1);
    expect_state("R12", 2);
    step(3);
    fb_uvp = 0; step(1);
    expect_state("R5", 3);
    step(2);

    sd = 1; step(1);
    expect_state("R9", 4);
    step(2);
    sd = 0; step(1);
    expect_state("R9", 1);
    step(W + 2);

    vcc_off = 1; sd = 1; step(1);
    expect_state("R10", 0);
    vcc_off = 0; step(2);
    expect_state("R10", 0);        // shutdown ignored in lockout
    sd = 0;

    fb_uvp = 1; vcc_on = 1; step(1);
    vcc_on = 0;
    step(W);
    expect_state("R4", 2);
    step(3);
    fb_uvp = 0; step(1);
    expect_state("R5", 3);
    trip = 1; rel = 1; step(2);
    trip = 0; step(2);
    vcc_off = 1; step(1);
    expect_state("R10", 0);
    vcc_off = 0; step(3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule